// File: doc/BRIEF.md
# Two-Stage Keyed Watchdog Timer

This block is a watchdog timer that runs on its own watchdog clock and is programmed through a simple word-addressed register port. When the timer is enabled, a counter runs for a selectable power-of-two interval, the interrupt period. At the end of that interval the timeout flag is raised and, if unmasked, an interrupt is driven. The counter then starts a second selectable interval, the reset period. If software has not serviced the watchdog before the reset period ends, the reset flag is raised and, if unmasked, a one-cycle system reset request is issued.

Servicing requires two consecutive writes to the service register: first 0xA5, then 0x5A. A successful service sets the count to zero and returns the timer to its first stage. The control register can be write-protected by writing a lock key to a separate lock register and is released by an unlock key. The period codes are scaled by a parameter `MAX_EXP`. A code n gives 2^(MAX_EXP-n) cycles, so with the default of 25, code 0 is 2^25 cycles and code 15 is 2^10 cycles.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the control, flag, mask and lock registers read zero. The control register is unlocked, and `irqOut` and `rstReqOut` are low.
- R2: A period code n in control bits [3:0] sets the timeout flag (flags bit 0) exactly 2^(MAX_EXP-n) clock cycles after the write that enabled the timer, or after the last service.
- R3: After the timeout flag is set, the reset flag (flags bit 2) is set a further 2^(MAX_EXP-m) cycles later, where m is control bits [7:4]. In that same cycle `rstReqOut` pulses high for exactly one cycle if mask bit 2 is set.
- R4: Writing 0xA5 and then 0x5A to the service register (word offset 0x04) on consecutive writes sets the count to zero and returns the timer to the interrupt stage. This applies in either stage, so a service during the reset period prevents the reset.
- R5: Any other value written to the service register cancels a started key sequence. A write of 0xA5 always arms the first step again, so the sequence A5, 00, 5A does not service the timer, but A5, A5, 5A does.
- R6: Writing 0x24 to lock register bits [7:0] (offset 0x14) makes writes to the control register ignored. Writing 0x42 re-enables them. Any other value leaves the lock unchanged. The lock state reads back in bit 0.
- R7: Mask register (offset 0x0C) bit 0 gates `irqOut` = timeout flag AND bit 0. Bit 2 gates the reset pulse. Both flags are set regardless of the mask.
- R8: Flags (offset 0x08) are write-one-to-clear. Writing 1 to bit 0 or bit 2 clears that flag, and writing 0 leaves it unchanged.
- R9: Control bit 8 enables the timer; while it is clear, the count is held at zero. Bit 9 enables the watchdog clock; while it is clear with bit 8 set, the count is frozen. Bit 10 is stored and read back. Control reads back its 11 bits at offset 0x00.
- R10: The reserved offset 0x10 and the service register always read zero, and writes to offset 0x10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register word |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data for `addr` |
| irqOut | output | 1 | Masked timeout interrupt (level) |
| rstReqOut | output | 1 | Masked one-cycle system reset request |

## Verification
The embedded assertions check the following on every cycle:
- the reset request is never wider than one cycle and always coincides with a set reset flag;
- a disabled timer holds its count at zero, and a gated clock freezes it;
- a completed key sequence zeroes the count and disarms the sequence;
- writes to the control register are dropped while locked;
- a write of one clears the timeout flag.

The exact period lengths for each code, the interplay of the two stages, and the key-sequence corner cases can only be shown by the bench's timed scenarios. These cases are a service during the reset stage, a broken sequence, and a re-armed sequence.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  // register word indices (byte offset / 4)
  localparam int IDX_CTRL = 0;
  localparam int IDX_KEY  = 1;
  localparam int IDX_FLAG = 2;
  localparam int IDX_MASK = 3;
  localparam int IDX_LOCK = 5;

  localparam int CTRL_W = 11;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;
  localparam logic [7:0] LOCK_KEY   = 8'h24;
  localparam logic [7:0] UNLOCK_KEY = 8'h42;

  // control -> datapath strobes
  typedef struct packed {
    logic       timerOn;
    logic       clkOn;
    logic       clrCnt;
    logic [3:0] intCode;
    logic [3:0] rstCode;
  } kwdCmd_t;

  // datapath -> control events
  typedef struct packed {
    logic intHit;
    logic rstHit;
  } kwdEvt_t;
endpackage

// File: rtl/kwd_counter.sv
module kwd_counter
  import kwd_pkg::*;
#(
  parameter int MAX_EXP = 25
) (
  input  logic    clk,
  input  logic    rstN,
  input  kwdCmd_t cmd,
  output kwdEvt_t evt
);
  localparam int CNT_W = MAX_EXP + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             inRstStage;
  logic [CNT_W-1:0] lim [2];
  logic [CNT_W-1:0] curLim;
  logic             atEnd;

  function automatic logic [CNT_W-1:0] lastCount(input logic [3:0] code);
    return (ONE << (MAX_EXP - int'(code))) - ONE;
  endfunction

  // one terminal-count decoder per stage
  for (genvar g = 0; g < 2; g++) begin : gLim
    assign lim[g] = lastCount((g == 0) ? cmd.intCode : cmd.rstCode);
  end

  always_comb begin
    curLim     = inRstStage ? lim[1] : lim[0];
    atEnd      = cmd.timerOn & cmd.clkOn & ~cmd.clrCnt & (cnt >= curLim);
    evt.intHit = atEnd & ~inRstStage;
    evt.rstHit = atEnd & inRstStage;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt        <= '0;
      inRstStage <= 1'b0;
    end else if (!cmd.timerOn || cmd.clrCnt) begin
      cnt        <= '0;
      inRstStage <= 1'b0;
    end else if (cmd.clkOn) begin
      if (atEnd) begin
        cnt        <= '0;
        inRstStage <= ~inRstStage;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end

  assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.timerOn |=> (cnt == '0) && !inRstStage);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.timerOn && !cmd.clkOn && !cmd.clrCnt) |=> $stable(cnt) && $stable(inRstStage));

  assert_service_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrCnt |=> (cnt == '0) && !inRstStage);
endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  kwdEvt_t           evt,
  output kwdCmd_t           cmd,
  output logic              irqOut,
  output logic              rstReqOut
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wIdx;
  logic [CTRL_W-1:0] ctrlReg;
  logic locked, toFlag, rsFlag, enIrq, enRst, keyArmed, rstReqQ;
  logic selCtrl, selKey, selFlag, selMask, selLock, keyDone;
  logic [7:0] wrByte;
  logic unusedBits;

  assign wIdx    = addr[ADDR_W-1:2];
  assign wrByte  = wrData[7:0];
  assign selCtrl = wrEn && (wIdx == WIDX_W'(IDX_CTRL));
  assign selKey  = wrEn && (wIdx == WIDX_W'(IDX_KEY));
  assign selFlag = wrEn && (wIdx == WIDX_W'(IDX_FLAG));
  assign selMask = wrEn && (wIdx == WIDX_W'(IDX_MASK));
  assign selLock = wrEn && (wIdx == WIDX_W'(IDX_LOCK));
  assign keyDone = selKey && keyArmed && (wrByte == KEY_SECOND);
  assign unusedBits = ^{addr[1:0], wrData[DATA_W-1:CTRL_W]};

  always_comb begin
    cmd.intCode = ctrlReg[3:0];
    cmd.rstCode = ctrlReg[7:4];
    cmd.timerOn = ctrlReg[8];
    cmd.clkOn   = ctrlReg[9];
    cmd.clrCnt  = keyDone;
  end

  // control register and its lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      locked  <= 1'b0;
    end else begin
      if (selCtrl && !locked) ctrlReg <= wrData[CTRL_W-1:0];
      if (selLock) begin
        if (wrByte == LOCK_KEY)        locked <= 1'b1;
        else if (wrByte == UNLOCK_KEY) locked <= 1'b0;
      end
    end
  end

  // service key sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       keyArmed <= 1'b0;
    else if (selKey) keyArmed <= (wrByte == KEY_FIRST);
  end

  // flags, masks and reset pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toFlag  <= 1'b0;
      rsFlag  <= 1'b0;
      enIrq   <= 1'b0;
      enRst   <= 1'b0;
      rstReqQ <= 1'b0;
    end else begin
      if (evt.intHit)                 toFlag <= 1'b1;
      else if (selFlag && wrData[0])  toFlag <= 1'b0;
      if (evt.rstHit)                 rsFlag <= 1'b1;
      else if (selFlag && wrData[2])  rsFlag <= 1'b0;
      if (selMask) begin
        enIrq <= wrData[0];
        enRst <= wrData[2];
      end
      rstReqQ <= evt.rstHit && enRst;
    end
  end

  assign irqOut    = toFlag & enIrq;
  assign rstReqOut = rstReqQ;

  always_comb begin
    rdData = '0;
    case (int'(wIdx))
      IDX_CTRL: rdData[CTRL_W-1:0] = ctrlReg;
      IDX_FLAG: begin rdData[0] = toFlag; rdData[2] = rsFlag; end
      IDX_MASK: begin rdData[0] = enIrq;  rdData[2] = enRst;  end
      IDX_LOCK: rdData[0] = locked;
      default:  rdData = '0;
    endcase
  end

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |=> !rstReqOut);

  assert_rst_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    rstReqOut |-> rsFlag);

  assert_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && selCtrl) |=> $stable(ctrlReg));

  assert_disarm_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrCnt |=> !keyArmed);

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rstN)
    (selFlag && wrData[0] && !evt.intHit) |=> !toFlag);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int MAX_EXP = 25,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              rstReqOut
);
  kwdCmd_t cmd;
  kwdEvt_t evt;

  kwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .evt(evt), .cmd(cmd), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  kwd_counter #(.MAX_EXP(MAX_EXP)) i_counter (
    .clk(clk), .rstN(rstN), .cmd(cmd), .evt(evt)
  );
endmodule

// File: tb/test_keyed_watchdog.sv
`timescale 1ns/1ps
module test_keyed_watchdog;
  localparam int MAXE = 19;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut, rstReqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  keyed_watchdog #(.MAX_EXP(MAXE)) i_keyed_watchdog (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  function automatic int plen(int code);
    return 1 << (MAXE - code);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // starts and ends at a falling edge; the write lands on the rising edge between
  task automatic wr(int a, logic [31:0] d);
    addr = a[4:0]; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = a[4:0];
    #1 d = rdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int seen;
    void'($urandom(32'd2024));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(0, v);  chk("R1 ctrl", v, 0);
    rd(8, v);  chk("R1 flags", v, 0);
    rd(12, v); chk("R1 mask", v, 0);
    rd(20, v); chk("R1 lock", v, 0);
    chk("R1 irq", irqOut, 0);
    chk("R1 rstReq", rstReqOut, 0);

    // R10 reserved and service register read zero
    wr(16, $urandom());
    rd(16, v); chk("R10 reserved", v, 0);
    wr(4, 32'h77);
    rd(4, v);  chk("R10 service read", v, 0);

    // R9 layout readback
    wr(0, 32'h7FF); rd(0, v); chk("R9 ctrl readback", v, 32'h7FF);
    wr(0, 0);       rd(0, v); chk("R9 ctrl cleared", v, 0);

    // R6 lock
    wr(20, 32'h24); rd(20, v); chk("R6 locked", v, 1);
    wr(0, 32'h123); rd(0, v);  chk("R6 write ignored", v, 0);
    wr(20, 32'h55); rd(20, v); chk("R6 other key", v, 1);
    wr(20, 32'h42); rd(20, v); chk("R6 unlocked", v, 0);
    wr(0, 32'h0AB); rd(0, v);  chk("R6 write accepted", v, 32'hAB);
    wr(0, 0);

    // R9 clock gate freezes, timer bit restarts
    wr(12, 1);
    wr(0, 32'h1FF); idle(40);
    chk("R9 gated clock no timeout", irqOut, 0);
    wr(0, 32'h3FF); idle(15);
    chk("R9 R2 before period", irqOut, 0);
    idle(1);
    chk("R9 R2 at period", irqOut, 1);
    wr(0, 0); wr(8, 5);

    // R5 broken sequence does not service
    wr(0, 32'h3FF); idle(5);
    wr(4, 32'hA5); wr(4, 32'h00); wr(4, 32'h5A);
    idle(7); chk("R5 broken seq early", irqOut, 0);
    idle(1); chk("R5 broken seq no service", irqOut, 1);
    wr(0, 0);
    // R8 writing zero keeps the flag, writing one clears it
    wr(8, 0);  rd(8, v); chk("R8 write zero keeps", v, 1);
    wr(8, 1);  rd(8, v); chk("R8 w1c", v, 0);

    // R5 re-armed sequence services
    wr(0, 32'h3FF); idle(5);
    wr(4, 32'hA5); wr(4, 32'hA5); wr(4, 32'h5A);
    idle(15); chk("R5 rearm serviced", irqOut, 0);
    idle(1);  chk("R5 R4 timeout after service", irqOut, 1);
    wr(0, 0); wr(8, 5);

    // R4 service during reset stage prevents reset
    wr(12, 5);
    wr(0, 32'h3FF); idle(16);
    chk("R4 stage one reached", irqOut, 1);
    idle(5);
    wr(4, 32'hA5); wr(4, 32'h5A);
    seen = 0;
    for (int t = 0; t < 20; t++) begin
      idle(1);
      if (rstReqOut) seen++;
    end
    chk("R4 no reset after service", seen, 0);
    rd(8, v); chk("R4 reset flag clear", v, 1);
    wr(0, 0); wr(8, 5);

    // R2 R3 R7 random periods, mask combinations
    for (int i = 0; i < 6; i++) begin
      int ic, rc, L, R;
      logic [31:0] en;
      ic = 12 + int'($urandom_range(3, 0));
      rc = 12 + int'($urandom_range(3, 0));
      en = {29'b0, i[1], 1'b0, i[0]};
      L = plen(ic);
      R = plen(rc);
      wr(12, en); wr(0, 0); wr(8, 5);
      wr(0, 32'h300 | (rc << 4) | ic);
      for (int t = 1; t <= L + R; t++) begin
        idle(1);
        chk("R2 R7 irq", irqOut, (en[0] && t >= L) ? 1 : 0);
        chk("R3 R7 rstReq", rstReqOut, (en[2] && t == L + R) ? 1 : 0);
      end
      rd(8, v); chk("R3 both flags", v, 5);
      wr(8, 5); rd(8, v); chk("R8 clear both", v, 0);
      wr(0, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule